// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for a four-beat memory burst. On a rising clock edge where either of two active-low start strobes is low, it loads a full start address. One strobe belongs to the processor and the other to the cache controller. After that load, each edge with the active-low advance input low moves the burst one beat forward. Only the two low-order address bits change from beat to beat. The upper bits keep the value they had at the start of the burst.

The beat order comes from an order-select pin. A low level selects a linear wrap order, and a high level selects an interleaved order that XORs the start bits with the beat count. The pin level is latched when a burst starts, so it can only take effect at the next start.

A build parameter can disconnect the pin. The order is then fixed by a second parameter, which defaults to interleaved, the level a floating pin takes. The outputs are the current address, the beat index, and a flag that shows which strobe opened the burst.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `addr_out`, `beat_idx` and `opened_by_ctrl` to 0, and selects the tied order (interleaved by default).
- R2: When `ads_proc_n` or `ads_ctrl_n` is low at a rising edge, `addr_in` is captured, and after that edge `beat_idx` is 0 and `addr_out` equals the captured address.
- R3: If both strobes are low at the same edge, the processor strobe wins and `opened_by_ctrl` becomes 0. If only `ads_ctrl_n` is low, it becomes 1.
- R4: With no strobe, `adv_n` low at an edge adds 1 modulo 4 to `beat_idx`, and `adv_n` high holds it. The fourth advance returns the burst to its start address.
- R5: In linear order (latched pin value 0), the low two bits of `addr_out` equal (start + `beat_idx`) mod 4. For example, start 2 gives 2, 3, 0, 1.
- R6: In interleaved order (latched pin value 1), the low two bits equal start XOR `beat_idx`. For example, start 1 gives 1, 0, 3, 2.
- R7: `order_pin` is sampled only on a start edge. A change during a burst does not affect the order until the next start.
- R8: Bits above the low two of `addr_out` change only on a start edge.
- R9: A strobe at the same edge as `adv_n` low restarts the burst at beat 0. The advance is dropped.
- R10: With `MODE_PIN_EN` = 0, `order_pin` is ignored and the order is always `MODE_TIE`, which defaults to interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ads_proc_n | input | 1 | Processor burst-start strobe, active low, higher priority |
| ads_ctrl_n | input | 1 | Cache-controller burst-start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr_in | input | ADDR_W | Start address, sampled on a start edge |
| order_pin | input | 1 | Order select: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current burst address |
| beat_idx | output | CNT_W | Current beat number 0..3 |
| opened_by_ctrl | output | 1 | 1 when the current burst was opened by the cache-controller strobe |

## Verification
The assertions assume the inputs are already synchronous to `clk` and settled at every rising edge. They also assume reset is held for at least one edge before any check counts. The bench changes every input only on the falling edge and holds reset for several edges.

The order pin is meant to be static, but the assertions do not depend on that. The random phase toggles it freely, mid-burst included, to show that the latched order is what counts. The strobe and advance densities are chosen so that restarts, collisions of both strobes, and four-beat wraps all occur many times.

// File: rtl/bseq_pkg.sv
`timescale 1ns/1ps
package bseq_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // Mask of the low w bits, w up to 8.
  function automatic logic [7:0] low_mask(input int unsigned w);
    logic [8:0] m;
    m = (9'd1 << w) - 9'd1;
    return m[7:0];
  endfunction

  // Linear wrap: start plus beat count, modulo 2**w.
  function automatic logic [7:0] seq_linear(input logic [7:0] s,
                                             input logic [7:0] c,
                                             input int unsigned w);
    return (s + c) & low_mask(w);
  endfunction

  // Interleaved: start bits flipped by the beat count.
  function automatic logic [7:0] seq_interleave(input logic [7:0] s,
                                                 input logic [7:0] c,
                                                 input int unsigned w);
    return (s ^ c) & low_mask(w);
  endfunction

endpackage

// File: rtl/bseq_capture.sv
`timescale 1ns/1ps
module bseq_capture
  import bseq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 2,
  parameter bit MODE_PIN_EN = 1'b1,
  parameter bit MODE_TIE    = 1'b1,
  localparam int HI_W       = ADDR_W - CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_p,
  input  logic              start_c,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              mode_pin,
  output logic [HI_W-1:0]   base_hi,
  output logic [CNT_W-1:0]  start_lo,
  output order_e            burst_order,
  output logic              owner_c
);

  logic   any_start;
  order_e mode_eff;

  assign any_start = start_p | start_c;

  generate
    if (MODE_PIN_EN) begin : g_pin
      assign mode_eff = order_e'(mode_pin);
    end else begin : g_tied
      assign mode_eff = order_e'(MODE_TIE);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      base_hi     <= '0;
      start_lo    <= '0;
      burst_order <= order_e'(MODE_TIE);
      owner_c     <= 1'b0;
    end else if (any_start) begin
      base_hi     <= addr_in[ADDR_W-1:CNT_W];
      start_lo    <= addr_in[CNT_W-1:0];
      burst_order <= mode_eff;
      owner_c     <= ~start_p;
    end
  end

  // R3: processor strobe wins a collision
  a_r3_proc_priority: assert property (@(posedge clk) disable iff (rst)
    start_p |=> !owner_c);
  // R3: controller-only start is flagged
  a_r3_ctrl_owner: assert property (@(posedge clk) disable iff (rst)
    (start_c && !start_p) |=> owner_c);
  // R7: latched order holds between starts
  a_r7_order_hold: assert property (@(posedge clk) disable iff (rst)
    !any_start |=> $stable(burst_order));
  // R8: upper base holds between starts
  a_r8_base_hold: assert property (@(posedge clk) disable iff (rst)
    !any_start |=> $stable(base_hi));

endmodule

// File: rtl/bseq_beat_ctr.sv
`timescale 1ns/1ps
module bseq_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             step,
  output logic [CNT_W-1:0] beat,
  output logic             wrap_evt
);

  logic beat_last;

  assign beat_last = (beat == {CNT_W{1'b1}});
  assign wrap_evt  = step & ~restart & beat_last;

  always_ff @(posedge clk) begin
    if (rst)          beat <= '0;
    else if (restart) beat <= '0;
    else if (step)    beat <= beat + CNT_W'(1);
  end

  // R2 / R9: a start always lands on beat 0
  a_r9_restart_zero: assert property (@(posedge clk) disable iff (rst)
    restart |=> (beat == '0));
  // R4: advance moves exactly one beat
  a_r4_step_one: assert property (@(posedge clk) disable iff (rst)
    (step && !restart) |=> (beat == CNT_W'($past(beat) + CNT_W'(1))));
  // R4: idle holds the beat
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !restart) |=> $stable(beat));
  // R4: last beat wraps to zero
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> (beat == '0));

endmodule

// File: rtl/bseq_order_map.sv
`timescale 1ns/1ps
module bseq_order_map
  import bseq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_lo,
  input  logic [CNT_W-1:0] beat,
  input  order_e           order,
  output logic [CNT_W-1:0] lo_out
);

  logic [7:0] lin_v;
  logic [7:0] ilv_v;

  always_comb begin
    lin_v = seq_linear(8'(start_lo), 8'(beat), CNT_W);
    ilv_v = seq_interleave(8'(start_lo), 8'(beat), CNT_W);
    if (order == ORD_LINEAR) lo_out = lin_v[CNT_W-1:0];
    else                     lo_out = ilv_v[CNT_W-1:0];
  end

endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 2,
  parameter bit MODE_PIN_EN = 1'b1,
  parameter bit MODE_TIE    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ads_proc_n,
  input  logic              ads_ctrl_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_pin,
  output logic [ADDR_W-1:0] addr_out,
  output logic [CNT_W-1:0]  beat_idx,
  output logic              opened_by_ctrl
);

  localparam int HI_W = ADDR_W - CNT_W;

  logic             start_p;
  logic             start_c;
  logic             burst_start;
  logic             step_req;
  logic [HI_W-1:0]  base_hi;
  logic [CNT_W-1:0] start_lo;
  logic [CNT_W-1:0] lo_cur;
  logic             wrap_evt;
  order_e           burst_order;

  assign start_p     = ~ads_proc_n;
  assign start_c     = ~ads_ctrl_n;
  assign burst_start = start_p | start_c;
  assign step_req    = ~adv_n & ~burst_start;

  bseq_capture #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .MODE_PIN_EN(MODE_PIN_EN), .MODE_TIE(MODE_TIE)
  ) cap_i (
    .clk(clk), .rst(rst), .start_p(start_p), .start_c(start_c),
    .addr_in(addr_in), .mode_pin(order_pin),
    .base_hi(base_hi), .start_lo(start_lo),
    .burst_order(burst_order), .owner_c(opened_by_ctrl)
  );

  bseq_beat_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk(clk), .rst(rst), .restart(burst_start), .step(step_req),
    .beat(beat_idx), .wrap_evt(wrap_evt)
  );

  bseq_order_map #(.CNT_W(CNT_W)) map_i (
    .start_lo(start_lo), .beat(beat_idx), .order(burst_order),
    .lo_out(lo_cur)
  );

  assign addr_out = {base_hi, lo_cur};

  // R2: first beat reproduces the captured address
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    burst_start |=> (addr_out == $past(addr_in)));
  // R8: upper address bits move only on a start
  a_r8_upper_stable: assert property (@(posedge clk) disable iff (rst)
    !burst_start |=> $stable(addr_out[ADDR_W-1:CNT_W]));
  // R4: a full wrap returns to the start address
  a_r4_wrap_addr: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> (addr_out[CNT_W-1:0] == start_lo));
  // R4: idle cycles leave the address alone
  a_r4_idle_addr: assert property (@(posedge clk) disable iff (rst)
    (!burst_start && adv_n) |=> $stable(addr_out));

endmodule

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;
  localparam int AW = 16;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1, order_pin = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out, addr_fix;
  logic [CW-1:0] beat_idx, beat_fix;
  logic owner, owner_fix;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n),
    .adv_n(adv_n), .addr_in(addr_in), .order_pin(order_pin),
    .addr_out(addr_out), .beat_idx(beat_idx), .opened_by_ctrl(owner));

  // R10: order pin disconnected, tied order applies
  burst_addr_seq #(.ADDR_W(AW), .CNT_W(CW), .MODE_PIN_EN(1'b0)) dut_fix_i (
    .clk(clk), .rst(rst), .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n),
    .adv_n(adv_n), .addr_in(addr_in), .order_pin(1'b0),
    .addr_out(addr_fix), .beat_idx(beat_fix), .opened_by_ctrl(owner_fix));

  int n_chk = 0;
  int n_fail = 0;

  logic [AW-1:0] m_base;
  logic [CW-1:0] m_beat;
  logic          m_ord;
  logic          m_own;

  function automatic logic [CW-1:0] exp_lo(input logic [CW-1:0] s,
                                            input logic [CW-1:0] b,
                                            input logic ord);
    logic [CW-1:0] r;
    if (ord) r = s ^ b;
    else     r = CW'(s + b);
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R4 beat", 64'(beat_idx), 64'(m_beat));
    chk(m_ord ? "R6 interleaved" : "R5 linear", 64'(addr_out[CW-1:0]),
        64'(exp_lo(m_base[CW-1:0], m_beat, m_ord)));
    chk("R8 upper", 64'(addr_out[AW-1:CW]), 64'(m_base[AW-1:CW]));
    chk("R3 owner", 64'(owner), 64'(m_own));
    chk("R10 tied", 64'(addr_fix[CW-1:0]), 64'(m_base[CW-1:0] ^ m_beat));
  endtask

  // Called at a falling edge: drive, model the next edge, check after it.
  task automatic cyc(input logic p_n, input logic c_n, input logic a_n,
                     input logic o, input logic [AW-1:0] a);
    ads_proc_n = p_n; ads_ctrl_n = c_n; adv_n = a_n; order_pin = o; addr_in = a;
    if (!p_n || !c_n) begin
      m_base = a; m_beat = '0; m_ord = o; m_own = p_n;
    end else if (!a_n) begin
      m_beat = CW'(m_beat + 1'b1);
    end
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [CW-1:0] lin_exp [4];
    logic [CW-1:0] ilv_exp [4];
    void'($urandom(32'd20240));
    lin_exp = '{2'd2, 2'd3, 2'd0, 2'd1};
    ilv_exp = '{2'd1, 2'd0, 2'd3, 2'd2};

    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_base = '0; m_beat = '0; m_ord = 1'b1; m_own = 1'b0;
    // R1: reset state
    chk("R1 addr", 64'(addr_out), 64'd0);
    chk("R1 beat", 64'(beat_idx), 64'd0);
    chk("R1 owner", 64'(owner), 64'd0);
    // R1: reset order is interleaved: advance from start 0 with beat 1 -> 1 either way, use beat 3 check via model
    cyc(1, 1, 0, 1, 16'h0000);

    // R5: linear, start 2, sequence 2,3,0,1 then wrap to 2
    cyc(0, 1, 1, 0, 16'hABC2);
    chk("R2 capture", 64'(addr_out), 64'hABC2);
    chk("R5 beat0", 64'(addr_out[1:0]), 64'(lin_exp[0]));
    for (int i = 1; i < 4; i++) begin
      cyc(1, 1, 0, 0, 16'h0);
      chk("R5 seq", 64'(addr_out[1:0]), 64'(lin_exp[i]));
    end
    cyc(1, 1, 0, 0, 16'h0);
    chk("R4 wrap", 64'(addr_out), 64'hABC2);

    // R6: interleaved, start 1, sequence 1,0,3,2
    cyc(1, 0, 1, 1, 16'h5551);
    chk("R2 ctrl capture", 64'(addr_out), 64'h5551);
    chk("R3 ctrl owner", 64'(owner), 64'd1);
    for (int i = 1; i < 4; i++) begin
      cyc(1, 1, 0, 1, 16'h0);
      chk("R6 seq", 64'(addr_out[1:0]), 64'(ilv_exp[i]));
    end
    // R4: hold with adv high
    cyc(1, 1, 1, 1, 16'hFFFF);
    chk("R4 hold", 64'(beat_idx), 64'd3);

    // R3: both strobes together, processor wins
    cyc(0, 0, 1, 0, 16'h1233);
    chk("R3 priority", 64'(owner), 64'd0);

    // R7: order pin flips mid-burst, linear start 1 continues linear (2, not 0)
    cyc(0, 1, 1, 0, 16'h0F01);
    cyc(1, 1, 0, 1, 16'h0);
    chk("R7 order latched", 64'(addr_out[1:0]), 64'd2);

    // R9: strobe with advance restarts at beat 0
    cyc(1, 1, 0, 1, 16'h0);
    cyc(0, 1, 0, 1, 16'h7772);
    chk("R9 restart beat", 64'(beat_idx), 64'd0);
    chk("R9 restart addr", 64'(addr_out), 64'h7772);

    // R10: tied instance interleaves start 2 beat 1 -> 3 while pin says linear
    cyc(0, 1, 1, 0, 16'h0002);
    cyc(1, 1, 0, 0, 16'h0);
    chk("R10 tied order", 64'(addr_fix[1:0]), 64'd3);

    // Random phase
    for (int k = 0; k < 3000; k++) begin
      logic p_n, c_n, a_n, o;
      p_n = ($urandom_range(0, 9) != 0);
      c_n = ($urandom_range(0, 9) != 0);
      a_n = ($urandom_range(0, 9) < 4);
      o   = 1'($urandom_range(0, 1));
      cyc(p_n, c_n, a_n, o, 16'($urandom()));
    end

    // R1: reset mid-burst clears outputs
    ads_proc_n = 1'b1; ads_ctrl_n = 1'b1; adv_n = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 re-reset addr", 64'(addr_out), 64'd0);
    chk("R1 re-reset beat", 64'(beat_idx), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule